// File: doc/BRIEF.md
# Multi-Width Banked Register File

This block holds the 64 general bytes of an 8051-compatible extended CPU core. The execution pipeline reaches the same storage through one write port and two read ports. Each port carries a width code and a register index, so a single access moves one byte, a 16-bit word or a 32-bit double word. Every width has its own legal index range and alignment. An access that breaks those rules is flagged on the port that made it. Multi-byte values are big-endian: the lowest register number holds the most significant byte.

Register indices 0 to 7 are banked. Two bank-select bits in the status byte move them onto one of four 8-byte windows in the lower 32 bytes. The accumulator, B, the two data-pointer bytes and the stack-pointer low byte are reached through a special-function-register (SFR) port. That port addresses the same storage cells that the register-file ports address. The status byte sits behind the SFR port too, and the block uses it only for its bank bits. Instruction decode and arithmetic are outside the block.

Top module: `regbank_core`

## Requirements
- R1: Width code 0 is a byte access. It is legal only for indices 0 to 15, and the byte sits in data bits [7:0].
- R2: Width code 1 is a word access. It is legal only for even indices 0 to 30. Register j goes to data bits [15:8] and register j+1 goes to bits [7:0].
- R3: Width code 2 is a double-word access. It is legal only for indices that are multiples of 4 and are at most 28, or are 56 or 60. Registers k, k+1, k+2 and k+3 go to data bits [31:24], [23:16], [15:8] and [7:0].
- R4: Width code 3 is never legal.
- R5: Status bits [4:3] give the bank number b. The block maps a register index i below 8 to storage byte 8*b+i. Indices 8 and up are never remapped, so storage bytes 16 to 31 can be seen through word and double-word indices 16 to 31.
- R6: An illegal access raises its port's illegal flag. An illegal read returns zero. An illegal write, including any byte or word access to indices 32 to 63, leaves every storage byte unchanged.
- R7: A write lands on the next rising clock edge. A read in the same cycle returns the newly written bytes and the stored values of all other bytes.
- R8: The SFR select codes are 0 accumulator (register 11), 1 B (register 10), 2 data-pointer low (register 59), 3 data-pointer high (register 58), 4 stack-pointer low (register 63) and 5 status byte. For codes 6 and 7 the SFR port reads zero and ignores writes. SFR reads show the stored value.
- R9: If the register-file write port and the SFR port write the same byte in one cycle, the register-file write port's data is stored.
- R10: Synchronous active-low reset clears every storage byte and the status byte, then sets register 63 to 0x07.
- R11: A register write uses the bank that was in force before a status write made in the same cycle. The status byte changes only through SFR code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_sel | input | 3 | SFR select code |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (stored value) |
| wr_en | input | 1 | Register-file write strobe |
| wr_width | input | 2 | Write width code |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 32 | Write data, right-justified |
| wr_illegal | output | 1 | Write strobe with an illegal width/index |
| rd0_width | input | 2 | Read port 0 width code |
| rd0_idx | input | 6 | Read port 0 register index |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 width/index illegal |
| rd1_width | input | 2 | Read port 1 width code |
| rd1_idx | input | 6 | Read port 1 register index |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 width/index illegal |

## Verification
Some cycles carry a register-file write together with an SFR write to the same storage byte. Examples are a byte write to register 11 alongside an accumulator write, and a double-word write to index 56 alongside a data-pointer write. The value stored afterwards is read back through the SFR port and the read ports, and the register-port data must have won. A status write that changes the bank is also issued in the same cycle as a write to index 0. The bench judges where that byte landed from a bank model that switches banks only after the edge. Every such cycle also reads the bytes being written, so bypass and collision are checked together.

// File: rtl/rf_pkg.sv
// Package: shared codes for the banked multi-width register file.
// Assumes: width codes and SFR select codes are fixed by the core's decoder.
package rf_pkg;
    localparam logic [1:0] WID_BYTE  = 2'd0;
    localparam logic [1:0] WID_WORD  = 2'd1;
    localparam logic [1:0] WID_DWORD = 2'd2;

    localparam logic [2:0] SFR_ACC = 3'd0;
    localparam logic [2:0] SFR_B   = 3'd1;
    localparam logic [2:0] SFR_DPL = 3'd2;
    localparam logic [2:0] SFR_DPH = 3'd3;
    localparam logic [2:0] SFR_SPL = 3'd4;
    localparam logic [2:0] SFR_PSW = 3'd5;
endpackage

// File: rtl/rf_lane_map.sv
// Module: rf_lane_map
// Turns one (width, index, bank) access into a legality bit and one storage
// byte address per data lane. Lane 0 is the least significant data byte.
// Assumes: big-endian packing, so lane l maps to register idx + nbytes-1-l;
// only registers below BANK_REGS are shifted by the bank number.
module rf_lane_map
    import rf_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int LANES      = 4,
    parameter int BANK_W     = 2,
    parameter int BANK_REGS  = 8,
    parameter int BYTE_LIMIT = 16,
    parameter int WORD_LIMIT = 32,
    parameter int DW_LIMIT   = 32,
    parameter int DW_HI_A    = 56,
    parameter int DW_HI_B    = 60
) (
    input  logic [1:0]                  width,
    input  logic [IDX_W-1:0]            idx,
    input  logic [BANK_W-1:0]           bank,
    output logic                        legal,
    output logic [LANES-1:0]            lane_en,
    output logic [LANES-1:0][IDX_W-1:0] lane_addr
);
    logic [2:0] nbytes;

    // Purpose: decide legality and byte count from the width rules.
    always_comb begin
        legal  = 1'b0;
        nbytes = 3'd4;
        case (width)
            WID_BYTE: begin
                nbytes = 3'd1;
                legal  = int'(idx) < BYTE_LIMIT;
            end
            WID_WORD: begin
                nbytes = 3'd2;
                legal  = (int'(idx) < WORD_LIMIT) && !idx[0];
            end
            WID_DWORD: begin
                nbytes = 3'd4;
                legal  = (idx[1:0] == 2'b00) &&
                         ((int'(idx) < DW_LIMIT) || (int'(idx) == DW_HI_A) ||
                          (int'(idx) == DW_HI_B));
            end
            default: begin
                nbytes = 3'd4;
                legal  = 1'b0;
            end
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W:0] logical;
        // Purpose: locate lane l's register and apply the bank window.
        always_comb begin
            logical      = (IDX_W+1)'(int'(idx) + int'(nbytes) - 1 - l);
            lane_en[l]   = legal && (l < int'(nbytes));
            if (logical < (IDX_W+1)'(BANK_REGS))
                lane_addr[l] = IDX_W'(int'(bank) * BANK_REGS + int'(logical));
            else
                lane_addr[l] = logical[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/rf_write_merge.sv
// Module: rf_write_merge
// Builds the next-state byte array from the stored array, the SFR write and
// the register-file write. The register-file write is applied last, so it
// wins any byte both ports touch in the same cycle.
// Assumes: lane addresses and enables are already legality-qualified.
module rf_write_merge #(
    parameter int NBYTES = 64,
    parameter int IDX_W  = 6,
    parameter int LANES  = 4
) (
    input  logic [NBYTES-1:0][7:0]      mem_q,
    input  logic                        sfr_go,
    input  logic [IDX_W-1:0]            sfr_addr,
    input  logic [7:0]                  sfr_byte,
    input  logic                        wr_go,
    input  logic [LANES-1:0]            lane_en,
    input  logic [LANES-1:0][IDX_W-1:0] lane_addr,
    input  logic [8*LANES-1:0]          wr_data,
    output logic [NBYTES-1:0][7:0]      mem_d
);
    // Purpose: overlay SFR then register-port bytes onto the stored array.
    always_comb begin
        mem_d = mem_q;
        if (sfr_go)
            mem_d[sfr_addr] = sfr_byte;
        for (int l = 0; l < LANES; l++) begin
            if (wr_go && lane_en[l])
                mem_d[lane_addr[l]] = wr_data[8*l +: 8];
        end
    end
endmodule

// File: rtl/rf_read_port.sv
// Module: rf_read_port
// One read port: maps the access and gathers lanes from the array view it is
// given (the next-state array, which provides write-through bypass).
// Assumes: disabled lanes and illegal accesses read as zero.
module rf_read_port #(
    parameter int NBYTES = 64,
    parameter int IDX_W  = 6,
    parameter int LANES  = 4,
    parameter int BANK_W = 2
) (
    input  logic [NBYTES-1:0][7:0] mem_view,
    input  logic [BANK_W-1:0]      bank,
    input  logic [1:0]             width,
    input  logic [IDX_W-1:0]       idx,
    output logic [8*LANES-1:0]     rd_data,
    output logic                   illegal
);
    logic                        legal;
    logic [LANES-1:0]            lane_en;
    logic [LANES-1:0][IDX_W-1:0] lane_addr;

    rf_lane_map #(.IDX_W(IDX_W), .LANES(LANES), .BANK_W(BANK_W)) u_map (
        .width    (width),
        .idx      (idx),
        .bank     (bank),
        .legal    (legal),
        .lane_en  (lane_en),
        .lane_addr(lane_addr)
    );

    // Purpose: flag an illegal read.
    always_comb illegal = !legal;

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        // Purpose: select lane l's byte or zero.
        always_comb rd_data[8*l +: 8] = lane_en[l] ? mem_view[lane_addr[l]] : 8'h00;
    end
endmodule

// File: rtl/regbank_core.sv
// Module: regbank_core
// 64-byte register file with byte/word/double-word ports, banked low
// registers and SFR aliases for accumulator, B, data pointer and stack
// pointer. Reads bypass same-cycle writes; SFR reads show stored values.
// Assumes: synchronous active-low reset; bank bits live in the status byte.
module regbank_core
    import rf_pkg::*;
#(
    parameter int         NBYTES   = 64,
    parameter int         LANES    = 4,
    parameter int         BANK_W   = 2,
    parameter int         BANK_LSB = 3,
    parameter int         ACC_IDX  = 11,
    parameter int         B_IDX    = 10,
    parameter int         DPL_IDX  = 59,
    parameter int         DPH_IDX  = 58,
    parameter int         SPL_IDX  = 63,
    parameter logic [7:0] SP_RST   = 8'h07
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sfr_we,
    input  logic [2:0]  sfr_sel,
    input  logic [7:0]  sfr_wdata,
    output logic [7:0]  sfr_rdata,
    input  logic        wr_en,
    input  logic [1:0]  wr_width,
    input  logic [5:0]  wr_idx,
    input  logic [31:0] wr_data,
    output logic        wr_illegal,
    input  logic [1:0]  rd0_width,
    input  logic [5:0]  rd0_idx,
    output logic [31:0] rd0_data,
    output logic        rd0_illegal,
    input  logic [1:0]  rd1_width,
    input  logic [5:0]  rd1_idx,
    output logic [31:0] rd1_data,
    output logic        rd1_illegal
);
    localparam int IDX_W = $clog2(NBYTES);

    logic [NBYTES-1:0][7:0]      mem_q, mem_d;
    logic [7:0]                  psw_q;
    logic [BANK_W-1:0]           bank;
    logic                        wr_legal, wr_go;
    logic [LANES-1:0]            wr_lane_en;
    logic [LANES-1:0][IDX_W-1:0] wr_lane_addr;
    logic                        sfr_hit;
    logic [IDX_W-1:0]            sfr_addr;

    // Purpose: extract the active bank from the stored status byte.
    always_comb bank = psw_q[BANK_LSB +: BANK_W];

    rf_lane_map #(.IDX_W(IDX_W), .LANES(LANES), .BANK_W(BANK_W)) u_wmap (
        .width    (wr_width),
        .idx      (wr_idx),
        .bank     (bank),
        .legal    (wr_legal),
        .lane_en  (wr_lane_en),
        .lane_addr(wr_lane_addr)
    );

    // Purpose: qualify the write strobe and flag illegal writes.
    always_comb begin
        wr_go      = wr_en && wr_legal;
        wr_illegal = wr_en && !wr_legal;
    end

    // Purpose: decode the SFR select into a storage byte or the status byte.
    always_comb begin
        sfr_hit   = 1'b1;
        sfr_addr  = IDX_W'(ACC_IDX);
        sfr_rdata = 8'h00;
        case (sfr_sel)
            SFR_ACC: begin sfr_addr = IDX_W'(ACC_IDX); sfr_rdata = mem_q[ACC_IDX]; end
            SFR_B:   begin sfr_addr = IDX_W'(B_IDX);   sfr_rdata = mem_q[B_IDX];   end
            SFR_DPL: begin sfr_addr = IDX_W'(DPL_IDX); sfr_rdata = mem_q[DPL_IDX]; end
            SFR_DPH: begin sfr_addr = IDX_W'(DPH_IDX); sfr_rdata = mem_q[DPH_IDX]; end
            SFR_SPL: begin sfr_addr = IDX_W'(SPL_IDX); sfr_rdata = mem_q[SPL_IDX]; end
            SFR_PSW: begin sfr_hit = 1'b0; sfr_rdata = psw_q; end
            default: sfr_hit = 1'b0;
        endcase
    end

    rf_write_merge #(.NBYTES(NBYTES), .IDX_W(IDX_W), .LANES(LANES)) u_merge (
        .mem_q    (mem_q),
        .sfr_go   (sfr_we && sfr_hit),
        .sfr_addr (sfr_addr),
        .sfr_byte (sfr_wdata),
        .wr_go    (wr_go),
        .lane_en  (wr_lane_en),
        .lane_addr(wr_lane_addr),
        .wr_data  (wr_data),
        .mem_d    (mem_d)
    );

    // Purpose: commit storage and status byte, or load the reset image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q          <= '0;
            mem_q[SPL_IDX] <= SP_RST;
            psw_q          <= 8'h00;
        end else begin
            mem_q <= mem_d;
            if (sfr_we && (sfr_sel == SFR_PSW))
                psw_q <= sfr_wdata;
        end
    end

    rf_read_port #(.NBYTES(NBYTES), .IDX_W(IDX_W), .LANES(LANES), .BANK_W(BANK_W)) u_rd0 (
        .mem_view(mem_d),
        .bank    (bank),
        .width   (rd0_width),
        .idx     (rd0_idx),
        .rd_data (rd0_data),
        .illegal (rd0_illegal)
    );

    rf_read_port #(.NBYTES(NBYTES), .IDX_W(IDX_W), .LANES(LANES), .BANK_W(BANK_W)) u_rd1 (
        .mem_view(mem_d),
        .bank    (bank),
        .width   (rd1_width),
        .idx     (rd1_idx),
        .rd_data (rd1_data),
        .illegal (rd1_illegal)
    );

    // R10: the cycle after reset shows the reset image.
    a_r10_reset_image: assert property (@(posedge clk)
        !rst_n |=> (mem_q[SPL_IDX] == SP_RST) && (psw_q == 8'h00) && (mem_q[0] == 8'h00));

    // R6: an illegal write with no SFR write leaves storage unchanged.
    a_r6_illegal_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_illegal && !sfr_we) |=> (mem_q == $past(mem_q)));

    // R1: a legal byte write lands at its mapped byte on the next edge.
    a_r1_byte_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && (wr_width == WID_BYTE) && !sfr_we)
        |=> (mem_q[$past(wr_lane_addr[0])] == $past(wr_data[7:0])));

    // R8: an accumulator SFR write reaches register 11.
    a_r8_acc_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && (sfr_sel == SFR_ACC) && !wr_en) |=> (mem_q[ACC_IDX] == $past(sfr_wdata)));

    // R9: register-port write beats an SFR write to the same byte.
    a_r9_regport_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && (wr_width == WID_BYTE) && (int'(wr_idx) == ACC_IDX) &&
         sfr_we && (sfr_sel == SFR_ACC)) |=> (mem_q[ACC_IDX] == $past(wr_data[7:0])));

    // R11: the status byte holds unless written through SFR code 5.
    a_r11_psw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_we && (sfr_sel == SFR_PSW)) |=> (psw_q == $past(psw_q)));
endmodule

// File: tb/regbank_core_bench.sv
`timescale 1ns/1ps
module regbank_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sfr_we;
    logic [2:0]  sfr_sel;
    logic [7:0]  sfr_wdata, sfr_rdata;
    logic        wr_en;
    logic [1:0]  wr_width;
    logic [5:0]  wr_idx;
    logic [31:0] wr_data;
    logic        wr_illegal;
    logic [1:0]  rd0_width, rd1_width;
    logic [5:0]  rd0_idx, rd1_idx;
    logic [31:0] rd0_data, rd1_data;
    logic        rd0_illegal, rd1_illegal;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] exp_m [64];
    logic [7:0] nxt_m [64];
    logic [7:0] exp_psw;

    always #2.5 clk = ~clk;

    regbank_core u_regbank_core (
        .clk(clk), .rst_n(rst_n),
        .sfr_we(sfr_we), .sfr_sel(sfr_sel), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .wr_en(wr_en), .wr_width(wr_width), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_illegal(wr_illegal),
        .rd0_width(rd0_width), .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
        .rd1_width(rd1_width), .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
    );

    // Legality from R1..R4.
    function automatic bit is_legal(input logic [1:0] w, input int i);
        case (w)
            2'd0:    return i < 16;
            2'd1:    return (i < 32) && (i % 2 == 0);
            2'd2:    return (i % 4 == 0) && ((i <= 28) || (i == 56) || (i == 60));
            default: return 1'b0;
        endcase
    endfunction

    function automatic int nbytes_of(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    endfunction

    // Bank window from R5.
    function automatic int phys(input int i, input int bank);
        return (i < 8) ? bank * 8 + i : i;
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] w, input int i, input int bank);
        logic [31:0] r = '0;
        if (!is_legal(w, i)) return r;
        for (int l = 0; l < nbytes_of(w); l++)
            r[8*l +: 8] = nxt_m[phys(i + nbytes_of(w) - 1 - l, bank)];
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] w);
        case (w)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; sfr_we = 1'b0; sfr_sel = 3'd6;
        wr_width = 2'd0; wr_idx = '0; wr_data = '0; sfr_wdata = '0;
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic tick(input string tag);
        int bank = int'(exp_psw[4:3]);
        logic [7:0] sfr_exp;
        #1;
        nxt_m = exp_m;
        if (sfr_we) begin
            case (sfr_sel)
                3'd0: nxt_m[11] = sfr_wdata;
                3'd1: nxt_m[10] = sfr_wdata;
                3'd2: nxt_m[59] = sfr_wdata;
                3'd3: nxt_m[58] = sfr_wdata;
                3'd4: nxt_m[63] = sfr_wdata;
                default: ;
            endcase
        end
        if (wr_en && is_legal(wr_width, int'(wr_idx)))
            for (int l = 0; l < nbytes_of(wr_width); l++)
                nxt_m[phys(int'(wr_idx) + nbytes_of(wr_width) - 1 - l, bank)] = wr_data[8*l +: 8];
        case (sfr_sel)
            3'd0: sfr_exp = exp_m[11];
            3'd1: sfr_exp = exp_m[10];
            3'd2: sfr_exp = exp_m[59];
            3'd3: sfr_exp = exp_m[58];
            3'd4: sfr_exp = exp_m[63];
            3'd5: sfr_exp = exp_psw;
            default: sfr_exp = 8'h00;
        endcase
        check({tag, " rd0 data ", tag_of(rd0_width)}, rd0_data, model_read(rd0_width, int'(rd0_idx), bank));
        check({tag, " rd0 flag ", tag_of(rd0_width)}, 32'(rd0_illegal), 32'(!is_legal(rd0_width, int'(rd0_idx))));
        check({tag, " rd1 data ", tag_of(rd1_width)}, rd1_data, model_read(rd1_width, int'(rd1_idx), bank));
        check({tag, " rd1 flag ", tag_of(rd1_width)}, 32'(rd1_illegal), 32'(!is_legal(rd1_width, int'(rd1_idx))));
        check({tag, " wr flag R6"}, 32'(wr_illegal), 32'(wr_en && !is_legal(wr_width, int'(wr_idx))));
        check({tag, " sfr read R8"}, 32'(sfr_rdata), 32'(sfr_exp));
        @(posedge clk);
        foreach (exp_m[k]) exp_m[k] = nxt_m[k];
        if (sfr_we && sfr_sel == 3'd5) exp_psw = sfr_wdata;
        @(negedge clk);
    endtask

    task automatic sweep(input string ctx);
        idle();
        for (int w = 0; w < 4; w++)
            for (int i = 0; i < 64; i++) begin
                rd0_width = 2'(w);     rd0_idx = 6'(i);
                rd1_width = 2'(3 - w); rd1_idx = 6'(63 - i);
                tick(ctx);
            end
    endtask

    task automatic set_bank(input int b);
        idle();
        sfr_we = 1'b1; sfr_sel = 3'd5; sfr_wdata = 8'(b << 3);
        tick("R11 bank write");
        idle(); sfr_sel = 3'd5;
        tick("R11 status readback");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10: got %0d cycles expected fewer", 150000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        idle();
        rst_n = 1'b0;
        rd0_width = 2'd2; rd0_idx = 6'd0; rd1_width = 2'd2; rd1_idx = 6'd60;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        foreach (exp_m[k]) exp_m[k] = 8'h00;
        exp_m[63] = 8'h07;
        exp_psw = 8'h00;

        // R10: reset image across every width and index.
        sweep("R10 reset");
        idle(); sfr_sel = 3'd4; tick("R10 stack low");

        // R5: fill each bank's low registers, then sweep under that bank.
        for (int b = 0; b < 4; b++) begin
            set_bank(b);
            for (int i = 0; i < 16; i++) begin
                idle();
                wr_en = 1'b1; wr_width = 2'd0; wr_idx = 6'(i);
                wr_data = 32'(8'(b * 64 + i * 13 + 5));
                rd0_width = 2'd0; rd0_idx = 6'(i);    // R7 bypass
                rd1_width = 2'd1; rd1_idx = 6'(i & 14);
                tick("R5 bank fill");
            end
            sweep("R5 bank view");
        end
        set_bank(0);

        // R1/R6: byte writes over all indices.
        for (int i = 0; i < 64; i++) begin
            idle();
            wr_en = 1'b1; wr_width = 2'd0; wr_idx = 6'(i); wr_data = 32'(8'(i) ^ 8'h3C);
            rd0_width = 2'd0; rd0_idx = 6'(i & 15);
            tick("R1 byte write");
        end
        sweep("R6 after byte writes");

        // R2/R6: word writes over all indices, read back in the same cycle.
        for (int i = 0; i < 64; i++) begin
            idle();
            wr_en = 1'b1; wr_width = 2'd1; wr_idx = 6'(i);
            wr_data = {16'h0, 8'(i), ~8'(i)};
            rd0_width = 2'd1; rd0_idx = 6'(i);
            rd1_width = 2'd2; rd1_idx = 6'(i & 60);
            tick("R2 word write");
        end
        sweep("R6 after word writes");

        // R3/R6: double-word writes over all indices.
        for (int i = 0; i < 64; i++) begin
            idle();
            wr_en = 1'b1; wr_width = 2'd2; wr_idx = 6'(i);
            wr_data = {8'(i), 8'(i + 1), ~8'(i), 8'h5A};
            rd0_width = 2'd2; rd0_idx = 6'(i);
            rd1_width = 2'd0; rd1_idx = 6'(i & 15);
            tick("R3 dword write");
        end
        sweep("R6 after dword writes");

        // R4: reserved width never writes.
        for (int i = 0; i < 64; i += 4) begin
            idle();
            wr_en = 1'b1; wr_width = 2'd3; wr_idx = 6'(i); wr_data = 32'hDEADBEEF;
            rd0_width = 2'd3; rd0_idx = 6'(i);
            tick("R4 reserved width");
        end
        sweep("R4 after reserved writes");

        // R7: partial bypass, word write under a double-word read.
        idle();
        wr_en = 1'b1; wr_width = 2'd1; wr_idx = 6'd8; wr_data = 32'h0000_A1B2;
        rd0_width = 2'd2; rd0_idx = 6'd8; rd1_width = 2'd1; rd1_idx = 6'd10;
        tick("R7 partial bypass");
        set_bank(3);
        idle();
        wr_en = 1'b1; wr_width = 2'd2; wr_idx = 6'd4; wr_data = 32'h1122_3344;
        rd0_width = 2'd1; rd0_idx = 6'd6; rd1_width = 2'd2; rd1_idx = 6'd28;
        tick("R7 banked bypass");

        // R8: every SFR code written, then read back both ways.
        for (int s = 0; s < 8; s++) begin
            if (s == 5) continue;
            idle();
            sfr_we = 1'b1; sfr_sel = 3'(s); sfr_wdata = 8'(8'hC0 + s);
            tick("R8 sfr write");
        end
        for (int s = 0; s < 8; s++) begin
            idle(); sfr_sel = 3'(s);
            rd0_width = 2'd0; rd0_idx = 6'd11; rd1_width = 2'd0; rd1_idx = 6'd10;
            tick("R8 sfr read");
        end
        idle();
        rd0_width = 2'd2; rd0_idx = 6'd56; rd1_width = 2'd2; rd1_idx = 6'd60;
        tick("R8 pointer view");

        // R9: same-byte collisions between the write ports.
        idle();
        wr_en = 1'b1; wr_width = 2'd0; wr_idx = 6'd11; wr_data = 32'h0000_00A5;
        sfr_we = 1'b1; sfr_sel = 3'd0; sfr_wdata = 8'h5A;
        rd0_width = 2'd0; rd0_idx = 6'd11;
        tick("R9 acc collision");
        idle(); sfr_sel = 3'd0; tick("R9 acc readback");
        idle();
        wr_en = 1'b1; wr_width = 2'd2; wr_idx = 6'd56; wr_data = 32'h0102_0304;
        sfr_we = 1'b1; sfr_sel = 3'd3; sfr_wdata = 8'hEE;
        rd0_width = 2'd2; rd0_idx = 6'd56;
        tick("R9 pointer collision");
        idle(); sfr_sel = 3'd3; tick("R9 pointer readback");

        // R11: status write and register write in one cycle.
        set_bank(1);
        idle();
        wr_en = 1'b1; wr_width = 2'd0; wr_idx = 6'd0; wr_data = 32'h0000_0077;
        sfr_we = 1'b1; sfr_sel = 3'd5; sfr_wdata = 8'h10;
        tick("R11 bank switch with write");
        idle(); sfr_sel = 3'd5;
        rd0_width = 2'd1; rd0_idx = 6'd8; rd1_width = 2'd2; rd1_idx = 6'd16;
        tick("R11 old bank holds write");
        sweep("R11 final view");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule